// File: doc/BRIEF.md
# Lock-Step Shared Memory with Conflict Resolution

This block is a small shared memory that several requesters use in lock-step. One clock cycle is one step. In each step every port may present one address together with a read enable, a write enable, or both. All reads in a step see the memory as it stood before the step. All writes land at the end of the step. When two or more ports touch the same address in the same step, the block applies two run-time controls to decide the result.

The access discipline (`accMode`) sets whether reads may be shared and whether writes may be shared. When sharing is forbidden and a collision happens, the block raises a violation flag. When writes may be shared, the write policy (`polSel`) decides what gets stored. The choices are: an equal-value check, a deterministic rotating pick, a wrapping sum, or a fixed port priority. The violation flag is a one-step pulse. System logic can use it to catch algorithms that break the discipline they claim to follow.

Top module: `shmem_resolver`

## Requirements
- R1: `rdData` for a port is registered. After a step in which that port's `rdEn` was high, it holds the word stored at that port's `addr` before the step's writes, and this value is visible from the following cycle. While `rdEn` is low, that port's `rdData` keeps its previous value.
- R2: A write to an address that no other port writes in the same step is stored. This holds under every discipline and every policy.
- R3: When `accMode` bit 1 is 0 (exclusive writes), two or more ports writing one address in the same step raise the violation flag, and that location keeps its old contents.
- R4: When `accMode` bit 0 is 0 (exclusive reads), two or more ports reading one address in the same step raise the violation flag. Read data is still returned. When bit 0 is 1, shared reads raise no flag.
- R5: With shared writes and `polSel` = 0 (equal-value), colliding writers that all carry the same data store that data with no flag. Any mismatch leaves the location unchanged and raises the flag.
- R6: With shared writes and `polSel` = 1 (rotating pick), the stored value comes from the first colliding writer found at or after a rotation pointer, searching upward by port index and wrapping. The pointer is 0 after reset. It advances by one, modulo the port count, after every step in which such a pick was made.
- R7: With shared writes and `polSel` = 2 (sum), the colliding data words are added and the sum is stored modulo 2^DATA_W.
- R8: With shared writes and `polSel` = 3 (priority), the colliding writer with the lowest port index wins.
- R9: `violFlag` is registered. It is high for exactly the cycle after a step that broke R3, R4 or R5, and low otherwise. After reset, `violFlag`, every `rdData` and every memory word are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rstN | input | 1 | Active-low synchronous reset |
| accMode | input | 2 | Bit 0: reads may be shared; bit 1: writes may be shared |
| polSel | input | 2 | Write policy: 0 equal-value, 1 rotating pick, 2 sum, 3 priority |
| addr | input | NUM_PORTS*ADDR_W | Per-port address, port 0 in the low bits |
| rdEn | input | NUM_PORTS | Per-port read request |
| wrEn | input | NUM_PORTS | Per-port write request |
| wrData | input | NUM_PORTS*DATA_W | Per-port write data, port 0 in the low bits |
| rdData | output | NUM_PORTS*DATA_W | Per-port registered read data |
| violFlag | output | 1 | One-cycle flag for a discipline or equal-value breach in the previous step |

## Verification
Corrupted memory contents stay hidden until some port reads the affected word. The bench therefore reads back heavily in every step, so a bad store shows up on `rdData` one step after the read that exposes it. A rotation pointer that drifts or skips shows up at the very next rotating-pick collision as the wrong winner. The sweep uses only two addresses, so such collisions recur within a few steps. A wrong violation decision appears on `violFlag` exactly one cycle after the offending step.

// File: rtl/shmem_pkg.sv
package shmem_pkg;
  localparam int ACC_SHARE_RD = 0;
  localparam int ACC_SHARE_WR = 1;

  typedef enum logic [1:0] {
    POL_EQUAL = 2'd0,
    POL_ROTATE = 2'd1,
    POL_SUM = 2'd2,
    POL_PRIO = 2'd3
  } wrPolicy_e;
endpackage

// File: rtl/shmem_ctrl.sv
module shmem_ctrl
  import shmem_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic [1:0] accMode,
  input  logic [1:0] polSel,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addrVec,
  input  logic [NUM_PORTS-1:0] rdEn,
  input  logic [NUM_PORTS-1:0] wrEn,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] dataVec,
  output logic [NUM_PORTS-1:0] commit,
  output logic [NUM_PORTS-1:0][NUM_PORTS-1:0] grp,
  output logic [NUM_PORTS-1:0][IDX_W-1:0] src,
  output logic doSum,
  output logic violFlag
);
  wrPolicy_e policy;
  logic [IDX_W-1:0] rotPtr;
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] rdGrp;
  logic [NUM_PORTS-1:0] leader;
  logic rdColl, wrColl, eqFail, rotHit;
  logic shareRd, shareWr;

  assign policy = wrPolicy_e'(polSel);
  assign shareRd = accMode[ACC_SHARE_RD];
  assign shareWr = accMode[ACC_SHARE_WR];
  assign doSum = (policy == POL_SUM);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_match
    for (genvar j = 0; j < NUM_PORTS; j++) begin : g_pair
      assign grp[i][j] = wrEn[i] && wrEn[j] && (addrVec[i] == addrVec[j]);
      assign rdGrp[i][j] = rdEn[i] && rdEn[j] && (addrVec[i] == addrVec[j]);
    end
  end

  always_comb begin
    rdColl = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if ($countones(rdGrp[i]) > 1) rdColl = 1'b1;
    end
  end

  always_comb begin
    wrColl = 1'b0;
    eqFail = 1'b0;
    rotHit = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      logic lead, found, same;
      int cnt;
      lead = wrEn[i];
      for (int j = 0; j < i; j++) begin
        if (grp[i][j]) lead = 1'b0;
      end
      leader[i] = lead;
      cnt = $countones(grp[i]);
      commit[i] = 1'b0;
      src[i] = IDX_W'(i);
      if (lead) begin
        if (cnt <= 1) begin
          commit[i] = 1'b1;
        end else begin
          wrColl = 1'b1;
          if (shareWr) begin
            unique case (policy)
              POL_EQUAL: begin
                same = 1'b1;
                for (int j = 0; j < NUM_PORTS; j++) begin
                  if (grp[i][j] && (dataVec[j] != dataVec[i])) same = 1'b0;
                end
                commit[i] = same;
                if (!same) eqFail = 1'b1;
              end
              POL_ROTATE: begin
                found = 1'b0;
                for (int k = 0; k < NUM_PORTS; k++) begin
                  int idx;
                  idx = (int'(rotPtr) + k) % NUM_PORTS;
                  if (!found && grp[i][idx]) begin
                    found = 1'b1;
                    src[i] = IDX_W'(idx);
                  end
                end
                commit[i] = 1'b1;
                rotHit = 1'b1;
              end
              default: commit[i] = 1'b1;
            endcase
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      violFlag <= 1'b0;
      rotPtr <= '0;
    end else begin
      violFlag <= (rdColl && !shareRd) || (wrColl && !shareWr) || eqFail;
      if (rotHit) begin
        rotPtr <= (int'(rotPtr) == NUM_PORTS - 1) ? '0 : rotPtr + 1'b1;
      end
    end
  end

  a_r3_excl_write_flag: assert property (@(posedge clk) disable iff (!rstN)
    (wrColl && !shareWr) |=> violFlag);

  a_r4_excl_read_flag: assert property (@(posedge clk) disable iff (!rstN)
    (rdColl && !shareRd) |=> violFlag);

  a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    !rotHit |=> $stable(rotPtr));

  a_r9_quiet_step: assert property (@(posedge clk) disable iff (!rstN)
    (!rdColl && !wrColl) |=> !violFlag);
endmodule

// File: rtl/shmem_datapath.sv
module shmem_datapath #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic clk,
  input  logic rstN,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] addrVec,
  input  logic [NUM_PORTS-1:0] rdEn,
  input  logic [NUM_PORTS-1:0] wrEn,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] dataVec,
  input  logic [NUM_PORTS-1:0] commit,
  input  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] grp,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0] src,
  input  logic doSum,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] rdQ
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [NUM_PORTS-1:0][DATA_W-1:0] wrVal;

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      logic [DATA_W-1:0] acc;
      acc = '0;
      for (int j = 0; j < NUM_PORTS; j++) begin
        if (grp[i][j]) acc = acc + dataVec[j];
      end
      wrVal[i] = doSum ? acc : dataVec[src[i]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (commit[i]) mem[addrVec[i]] <= wrVal[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (rdEn[i]) rdQ[i] <= mem[addrVec[i]];
      end
    end
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
    a_r2_commit_needs_write: assert property (@(posedge clk) disable iff (!rstN)
      commit[i] |-> wrEn[i]);
    a_r1_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
      !rdEn[i] |=> $stable(rdQ[i]));
    for (genvar j = i + 1; j < NUM_PORTS; j++) begin : g_pair
      a_r6_single_store: assert property (@(posedge clk) disable iff (!rstN)
        !(commit[i] && commit[j] && (addrVec[i] == addrVec[j])));
    end
  end
endmodule

// File: rtl/shmem_resolver.sv
module shmem_resolver #(
  parameter int NUM_PORTS = 4,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  localparam int IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic [1:0] accMode,
  input  logic [1:0] polSel,
  input  logic [NUM_PORTS*ADDR_W-1:0] addr,
  input  logic [NUM_PORTS-1:0] rdEn,
  input  logic [NUM_PORTS-1:0] wrEn,
  input  logic [NUM_PORTS*DATA_W-1:0] wrData,
  output logic [NUM_PORTS*DATA_W-1:0] rdData,
  output logic violFlag
);
  typedef struct packed {
    logic [NUM_PORTS-1:0] commit;
    logic [NUM_PORTS-1:0][NUM_PORTS-1:0] grp;
    logic [NUM_PORTS-1:0][IDX_W-1:0] src;
    logic doSum;
  } strobe_t;

  strobe_t stb;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addrVec;
  logic [NUM_PORTS-1:0][DATA_W-1:0] dataVec;
  logic [NUM_PORTS-1:0][DATA_W-1:0] rdQ;

  assign addrVec = addr;
  assign dataVec = wrData;
  assign rdData = rdQ;

  shmem_ctrl #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .accMode(accMode), .polSel(polSel),
    .addrVec(addrVec), .rdEn(rdEn), .wrEn(wrEn), .dataVec(dataVec),
    .commit(stb.commit), .grp(stb.grp), .src(stb.src), .doSum(stb.doSum),
    .violFlag(violFlag)
  );

  shmem_datapath #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .addrVec(addrVec), .rdEn(rdEn), .wrEn(wrEn),
    .dataVec(dataVec), .commit(stb.commit), .grp(stb.grp), .src(stb.src),
    .doSum(stb.doSum), .rdQ(rdQ)
  );
endmodule

// File: tb/sim_shmem_resolver.sv
module sim_shmem_resolver;
  localparam int N = 4;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] accMode = '0;
  logic [1:0] polSel = '0;
  logic [N-1:0] rdEn = '0;
  logic [N-1:0] wrEn = '0;
  logic [AW-1:0] aTb [N];
  logic [DW-1:0] dTb [N];
  logic [N*AW-1:0] addr;
  logic [N*DW-1:0] wrData;
  logic [N*DW-1:0] rdData;
  logic violFlag;

  logic [DW-1:0] mdlMem [DEPTH];
  logic [DW-1:0] expRd [N];
  int ptr = 0;
  int checks = 0;
  int bad = 0;

  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      addr[i*AW +: AW] = aTb[i];
      wrData[i*DW +: DW] = dTb[i];
    end
  end

  shmem_resolver #(.NUM_PORTS(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .accMode(accMode), .polSel(polSel), .addr(addr),
    .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .violFlag(violFlag)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearIn();
    rdEn = '0;
    wrEn = '0;
    for (int i = 0; i < N; i++) begin
      aTb[i] = '0;
      dTb[i] = '0;
    end
  endtask

  task automatic setPort(input int p, input bit rd, input bit wr, input int a, input int d);
    rdEn[p] = rd;
    wrEn[p] = wr;
    aTb[p] = AW'(a);
    dTb[p] = DW'(d);
  endtask

  // Reference step built from the requirement text, then compare after the edge.
  task automatic doStep(input string tag);
    logic [DW-1:0] nxt [DEPTH];
    bit expViol;
    bit rotUsed;
    expViol = 1'b0;
    rotUsed = 1'b0;
    for (int a = 0; a < DEPTH; a++) nxt[a] = mdlMem[a];
    for (int i = 0; i < N; i++) begin
      if (rdEn[i]) begin
        expRd[i] = mdlMem[aTb[i]];
        for (int j = 0; j < N; j++)
          if (j != i && rdEn[j] && aTb[j] == aTb[i] && !accMode[0]) expViol = 1'b1;
      end
    end
    for (int i = 0; i < N; i++) begin
      bit lead;
      bit allEq;
      int cnt;
      logic [DW-1:0] sum;
      if (!wrEn[i]) continue;
      lead = 1'b1;
      for (int j = 0; j < i; j++) if (wrEn[j] && aTb[j] == aTb[i]) lead = 1'b0;
      if (!lead) continue;
      cnt = 0;
      sum = '0;
      allEq = 1'b1;
      for (int j = 0; j < N; j++) begin
        if (wrEn[j] && aTb[j] == aTb[i]) begin
          cnt++;
          sum = sum + dTb[j];
          if (dTb[j] != dTb[i]) allEq = 1'b0;
        end
      end
      if (cnt == 1) nxt[aTb[i]] = dTb[i];
      else if (!accMode[1]) expViol = 1'b1;
      else begin
        case (polSel)
          2'd0: if (allEq) nxt[aTb[i]] = dTb[i]; else expViol = 1'b1;
          2'd1: begin
            bit got;
            got = 1'b0;
            for (int k = 0; k < N; k++) begin
              int idx;
              idx = (ptr + k) % N;
              if (!got && wrEn[idx] && aTb[idx] == aTb[i]) begin
                got = 1'b1;
                nxt[aTb[i]] = dTb[idx];
              end
            end
            rotUsed = 1'b1;
          end
          2'd2: nxt[aTb[i]] = sum;
          default: nxt[aTb[i]] = dTb[i];
        endcase
      end
    end
    if (rotUsed) ptr = (ptr + 1) % N;
    for (int a = 0; a < DEPTH; a++) mdlMem[a] = nxt[a];
    @(posedge clk);
    @(negedge clk);
    check({tag, " R9 violFlag"}, DW'(violFlag), DW'(expViol));
    for (int i = 0; i < N; i++) check({tag, " R1 rdData"}, rdData[i*DW +: DW], expRd[i]);
    clearIn();
  endtask

  // Reads every location through port 0 so stored contents reach the ports.
  task automatic dumpAll(input string tag);
    for (int a = 0; a < DEPTH; a++) begin
      setPort(0, 1, 0, a, 0);
      doStep(tag);
    end
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    clearIn();
    for (int a = 0; a < DEPTH; a++) mdlMem[a] = '0;
    for (int i = 0; i < N; i++) expRd[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 reset violFlag", DW'(violFlag), '0);
    for (int i = 0; i < N; i++) check("R9 reset rdData", rdData[i*DW +: DW], '0);
    dumpAll("R9 reset memory");

    accMode = 2'b00;
    setPort(1, 0, 1, 5, 77); doStep("R2 single write");
    setPort(2, 1, 1, 5, 9); doStep("R1 read before write");
    setPort(2, 1, 0, 5, 0); doStep("R1 read after write");
    setPort(0, 1, 0, 5, 0); doStep("R1 hold other ports");
    setPort(0, 0, 1, 3, 11); setPort(3, 0, 1, 3, 12); doStep("R3 exclusive write clash");
    dumpAll("R3 unchanged");
    setPort(0, 1, 0, 5, 0); setPort(1, 1, 0, 5, 0); doStep("R4 exclusive read clash");
    accMode = 2'b01;
    setPort(0, 1, 0, 5, 0); setPort(1, 1, 0, 5, 0); doStep("R4 shared read ok");

    accMode = 2'b11;
    polSel = 2'd0;
    setPort(1, 0, 1, 2, 40); setPort(2, 0, 1, 2, 40); doStep("R5 equal data");
    setPort(1, 0, 1, 2, 41); setPort(3, 0, 1, 2, 42); doStep("R5 mismatch");
    dumpAll("R5 contents");
    polSel = 2'd1;
    setPort(0, 0, 1, 4, 1); setPort(2, 0, 1, 4, 3); doStep("R6 pick ptr0");
    setPort(0, 0, 1, 4, 1); setPort(2, 0, 1, 4, 3); doStep("R6 pick ptr1");
    setPort(1, 0, 1, 4, 2); setPort(3, 0, 1, 4, 4); doStep("R6 pick ptr2");
    dumpAll("R6 contents");
    polSel = 2'd2;
    setPort(0, 0, 1, 6, 200); setPort(1, 0, 1, 6, 100); doStep("R7 wrap sum");
    dumpAll("R7 contents");
    polSel = 2'd3;
    setPort(1, 0, 1, 7, 21); setPort(3, 0, 1, 7, 23); doStep("R8 lowest index");
    dumpAll("R8 contents");

    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 4; p++) begin
        accMode = 2'(m);
        polSel = 2'(p);
        for (int s = 0; s < 120; s++) begin
          for (int i = 0; i < N; i++) begin
            setPort(i, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                    int'($urandom_range(0, 1)), int'($urandom_range(0, 3)) * 70);
          end
          doStep("R2 R3 R4 R5 R6 R7 R8 sweep");
        end
        dumpAll("R2 sweep contents");
      end
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule